// File: doc/BRIEF.md
# Compression Header Selector and Validator

This block supplies the user-data compression header that applies to each U-plane section and checks that header. An 8-bit header has two fields: the IQ sample width in bits 7:4 and the compression method in bits 3:0. A mode bit picks the header source. In static mode the block uses a programmed header register. In dynamic mode it uses the header byte that arrives in-band with each section strobe.

For every section strobe, the block decodes the chosen header and presents the results to downstream logic for one cycle with a valid pulse. The decoded width is a 5-bit sample count. The method is a one-hot code. Reserved method codes do not stop the section: it is still forwarded, marked invalid so downstream logic drops it. The same event also sets a sticky error bit. Software clears that bit by writing 1, and a mask bit keeps it off the interrupt line.

A small register port holds the static header, the mode bit, the sticky error and the mask. A registered read path returns each register with its unused upper bits at zero.

Top module: `comp_hdr_check`

## Requirements
- R1: Width code bits 7:4 decode to `hdr_width_o`: code 0 gives 16, and codes 1..15 give the same value.
- R2: Method code bits 3:0 decode to one-hot `hdr_meth_o`: code 0 gives bit 0 (no compression), code 1 gives bit 1 (block floating point), code 3 gives bit 2 (mu-law), and any other code gives 0.
- R3: With mode 0 (static) the decoded header is the programmed header register. With mode 1 (dynamic) it is `sec_hdr_i` taken at the strobe.
- R4: The mode in effect for a section is the mode register value at its strobe edge. `hdr_mode_o` reports it and changes only in the cycle after a strobe, so a mode write in the same cycle as a strobe acts only from the next section.
- R5: A section with a reserved method code is still output with `hdr_vld_o`=1 and carries `hdr_bad_o`=1. Valid sections carry `hdr_bad_o`=0.
- R6: A reserved-method section sets sticky `err_o` in the output cycle. Only a write of 1 in bit 0 to address 2 clears it, and a write of 0 leaves it set. A new error in the same cycle as a clear leaves it set.
- R7: `irq_o` is `err_o` gated by the mask bit (address 3, bit 0; 1 = masked).
- R8: The register map is address 0 = static header [7:0], 1 = mode [0], 2 = error [0], 3 = mask [0]. `cfg_rdata_o` returns the addressed register one cycle after the address is presented, with all other bits zero.
- R9: After reset all registers, `cfg_rdata_o` and all section outputs are 0.
- R10: `hdr_vld_o` is high for exactly the one cycle that follows each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address (write and read) |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 32 | Registered read data |
| sec_stb_i | input | 1 | Section strobe |
| sec_hdr_i | input | 8 | In-band header byte of the section |
| hdr_vld_o | output | 1 | Decoded header valid pulse |
| hdr_width_o | output | 5 | Sample width, 1..16 |
| hdr_meth_o | output | 3 | One-hot method |
| hdr_bad_o | output | 1 | Section carries a reserved method |
| hdr_mode_o | output | 1 | Mode used for the last section |
| err_o | output | 1 | Sticky error |
| irq_o | output | 1 | Masked error interrupt |

## Verification
The bench targets width code 0. A decoder that passes the code through unchanged would report width 0 instead of 16. Each vector uses a static header and an in-band byte that decode to different values, so choosing the wrong source shows up as a wrong width or method. A mode write in the same cycle as a strobe checks that the new mode waits for the next section; a design that switched at once would decode from the other source. Clearing the error in the same cycle as a new error checks that the error wins; a design that let the clear win would drop that error.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int HDR_W   = 8;
  localparam int WIDTH_W = 5;
  localparam int METH_W  = 3;

  // one-hot method positions
  localparam int OH_NONE  = 0;
  localparam int OH_BFP   = 1;
  localparam int OH_MULAW = 2;

  function automatic logic [WIDTH_W-1:0] width_of(input logic [3:0] code);
    return (code == 4'd0) ? WIDTH_W'(16) : {1'b0, code};
  endfunction

  function automatic logic [METH_W-1:0] meth_of(input logic [3:0] code);
    logic [METH_W-1:0] oh;
    oh = '0;
    case (code)
      4'd0:    oh[OH_NONE]  = 1'b1;
      4'd1:    oh[OH_BFP]   = 1'b1;
      4'd3:    oh[OH_MULAW] = 1'b1;
      default: oh = '0;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/chs_cfg_regs.sv
module chs_cfg_regs #(
  parameter int CFG_AW = 2,
  parameter int CFG_DW = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [chs_pkg::HDR_W-1:0]   cfg_wdata,
  input  logic                        bad_evt,
  output logic [chs_pkg::HDR_W-1:0]   static_hdr,
  output logic                        mode,
  output logic                        err,
  output logic                        mask,
  output logic [CFG_DW-1:0]           rdata
);
  localparam logic [CFG_AW-1:0] A_HDR  = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_MODE = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_ERR  = CFG_AW'(2);
  localparam logic [CFG_AW-1:0] A_MASK = CFG_AW'(3);

  logic clr_req;
  logic [CFG_DW-1:0] rd_mux;

  assign clr_req = cfg_we && (cfg_addr == A_ERR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      static_hdr <= '0;
      mode       <= 1'b0;
      mask       <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_HDR)  static_hdr <= cfg_wdata;
      if (cfg_we && cfg_addr == A_MODE) mode       <= cfg_wdata[0];
      if (cfg_we && cfg_addr == A_MASK) mask       <= cfg_wdata[0];
      // new error wins over a clear in the same cycle
      err <= bad_evt | (err & ~clr_req);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      A_HDR:   rd_mux[chs_pkg::HDR_W-1:0] = static_hdr;
      A_MODE:  rd_mux[0] = mode;
      A_ERR:   rd_mux[0] = err;
      A_MASK:  rd_mux[0] = mask;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
    bad_evt |=> err);
  assert_err_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (err && !clr_req) |=> err);
  assert_mode_rd_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == A_MODE && !cfg_we) |=> (rdata[CFG_DW-1:1] == '0));
endmodule

// File: rtl/chs_hdr_sel.sv
module chs_hdr_sel (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sec_stb,
  input  logic [chs_pkg::HDR_W-1:0]     sec_hdr,
  input  logic [chs_pkg::HDR_W-1:0]     static_hdr,
  input  logic                          mode,
  output logic                          bad_evt,
  output logic                          out_vld,
  output logic [chs_pkg::WIDTH_W-1:0]   out_width,
  output logic [chs_pkg::METH_W-1:0]    out_meth,
  output logic                          out_bad,
  output logic                          out_mode
);
  import chs_pkg::*;

  logic [HDR_W-1:0]   sel_hdr;
  logic [METH_W-1:0]  meth_d;
  logic [WIDTH_W-1:0] width_d;

  // mode is sampled only at a section strobe
  assign sel_hdr = mode ? sec_hdr : static_hdr;
  assign width_d = width_of(sel_hdr[7:4]);
  assign meth_d  = meth_of(sel_hdr[3:0]);
  assign bad_evt = sec_stb && (meth_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_width <= '0;
      out_meth  <= '0;
      out_bad   <= 1'b0;
      out_mode  <= 1'b0;
    end else begin
      out_vld <= sec_stb;
      if (sec_stb) begin
        out_width <= width_d;
        out_meth  <= meth_d;
        out_bad   <= (meth_d == '0);
        out_mode  <= mode;
      end
    end
  end

  assert_width_range_R1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_width != '0 && out_width <= WIDTH_W'(16)));
  assert_meth_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($onehot0(out_meth) && (out_bad == (out_meth == '0))));
  assert_mode_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !sec_stb |=> $stable(out_mode));
  assert_vld_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !sec_stb) |=> !out_vld);
endmodule

// File: rtl/comp_hdr_check.sv
module comp_hdr_check #(
  parameter int CFG_AW = 2,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [CFG_DW-1:0] cfg_rdata_o,
  input  logic              sec_stb_i,
  input  logic [7:0]        sec_hdr_i,
  output logic              hdr_vld_o,
  output logic [4:0]        hdr_width_o,
  output logic [2:0]        hdr_meth_o,
  output logic              hdr_bad_o,
  output logic              hdr_mode_o,
  output logic              err_o,
  output logic              irq_o
);
  logic [7:0] static_hdr;
  logic       mode, err, mask, bad_evt;

  chs_cfg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we_i), .cfg_addr(cfg_addr_i),
    .cfg_wdata(cfg_wdata_i), .bad_evt(bad_evt), .static_hdr(static_hdr),
    .mode(mode), .err(err), .mask(mask), .rdata(cfg_rdata_o)
  );

  chs_hdr_sel u_sel (
    .clk(clk), .rst(rst), .sec_stb(sec_stb_i), .sec_hdr(sec_hdr_i),
    .static_hdr(static_hdr), .mode(mode), .bad_evt(bad_evt),
    .out_vld(hdr_vld_o), .out_width(hdr_width_o), .out_meth(hdr_meth_o),
    .out_bad(hdr_bad_o), .out_mode(hdr_mode_o)
  );

  assign err_o = err;
  assign irq_o = err & ~mask;
endmodule

// File: tb/test_comp_hdr_check.sv
`timescale 1ns/1ps
module test_comp_hdr_check;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic sec_stb = 1'b0;
  logic [7:0] sec_hdr = '0;
  logic vld, bad, mode_o, err, irq;
  logic [4:0] width;
  logic [2:0] meth;
  int total = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  comp_hdr_check i_comp_hdr_check (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .sec_stb_i(sec_stb),
    .sec_hdr_i(sec_hdr), .hdr_vld_o(vld), .hdr_width_o(width),
    .hdr_meth_o(meth), .hdr_bad_o(bad), .hdr_mode_o(mode_o),
    .err_o(err), .irq_o(irq)
  );

  // {mode, static_hdr, inband_hdr, exp_width, exp_meth, exp_bad}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h31, 5'd16, 3'b001, 1'b0},
    {1'b0, 8'h91, 8'h00, 5'd9,  3'b010, 1'b0},
    {1'b0, 8'hF3, 8'h10, 5'd15, 3'b100, 1'b0},
    {1'b1, 8'h91, 8'h13, 5'd1,  3'b100, 1'b0},
    {1'b1, 8'h00, 8'h81, 5'd8,  3'b010, 1'b0},
    {1'b1, 8'h13, 8'h20, 5'd2,  3'b001, 1'b0},
    {1'b1, 8'h00, 8'h02, 5'd16, 3'b000, 1'b1},
    {1'b0, 8'hCF, 8'h01, 5'd12, 3'b000, 1'b1}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic section(input logic [7:0] h);
    @(negedge clk); sec_stb = 1'b1; sec_hdr = h;
    @(negedge clk); sec_stb = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nbad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 vld", vld, 0); chk("R9 width", width, 0); chk("R9 meth", meth, 0);
    chk("R9 err", err, 0); chk("R9 irq", irq, 0); chk("R9 mode", mode_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r); chk("R9 rdata", r, 0);
    end

    // vector table: R1 R2 R3 R5
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, VEC[i][24:17]);
      wr(2'd1, {7'd0, VEC[i][25]});
      section(VEC[i][16:9]);
      chk("R10 vld", vld, 1);
      chk("R1 width", width, VEC[i][8:4]);
      chk("R2 meth", meth, VEC[i][3:1]);
      chk("R5 bad", bad, VEC[i][0]);
      chk("R3 mode", mode_o, VEC[i][25]);
      @(negedge clk);
      chk("R10 vld drop", vld, 0);
    end

    // R6 / R7 sticky error and mask
    chk("R6 err held", err, 1);
    chk("R7 irq unmasked", irq, 1);
    wr(2'd3, 8'h01);
    chk("R7 irq masked", irq, 0);
    chk("R7 err under mask", err, 1);
    wr(2'd2, 8'h00);
    chk("R6 write0 no clear", err, 1);
    wr(2'd2, 8'h01);
    chk("R6 write1 clears", err, 0);
    // clear and new error together: error wins (mode currently 0, static CF)
    @(negedge clk); sec_stb = 1'b1; sec_hdr = 8'h00;
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h01;
    @(negedge clk); sec_stb = 1'b0; cfg_we = 1'b0;
    chk("R6 set beats clear", err, 1);
    chk("R5 bad forwarded", vld, 1);
    wr(2'd3, 8'h00);
    chk("R7 irq unmask", irq, 1);

    // R4 mode change at section boundary
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    @(negedge clk); sec_stb = 1'b1; sec_hdr = 8'h81;
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'h00;
    @(negedge clk); sec_stb = 1'b0; cfg_we = 1'b0;
    chk("R4 old mode width", width, 8);
    chk("R4 old mode flag", mode_o, 1);
    @(negedge clk);
    chk("R4 mode held between sections", mode_o, 1);
    section(8'h81);
    chk("R4 new mode width", width, 16);
    chk("R4 new mode flag", mode_o, 0);

    // R8 readback and zero upper bits
    wr(2'd0, 8'hA5);
    rd(2'd0, r); chk("R8 hdr read", r, 32'h0000_00A5);
    wr(2'd1, 8'hFF);
    rd(2'd1, r); chk("R8 mode read", r, 32'h1);
    rd(2'd2, r); chk("R8 err read", r, 32'h1);
    wr(2'd3, 8'hFE);
    rd(2'd3, r); chk("R8 mask read", r, 32'h0);

    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end
endmodule